// File: doc/BRIEF.md
# I/O Translation Performance Counter Bank

This block is a bank of hardware performance counters for an I/O address-translation unit. Slot 0 is a free-running cycle counter. Slots 1 to NUM_CTR-1 are event counters. Each event counter is steered by a 64-bit selector. The selector names one of eight pipeline events and can restrict counting to a process tag, a device tag and a tag type. Tag comparison is exact by default. An optional partial mode treats the low bits of the programmed value as wildcards.

Software reaches the bank over a plain 64-bit register port. Writes take effect on the clock edge. Reads are combinational from the byte address. A per-slot inhibit register freezes counters, and it comes out of reset with every slot frozen. A wrap from all ones to zero sets that slot's sticky overflow status bit. When the slot's overflow-suppress flag (OF) is clear, the wrap also sets OF and raises the level interrupt. Software clears a status bit by writing 1 to it.

Top module: `hpm_bank`

## Requirements
- R1: After reset the inhibit register reads all ones for the implemented slots, all counters, selectors and the overflow status read zero, and `irq` is low.
- R2: The cycle counter (slot 0, byte address 0x060) adds one on every clock edge while inhibit bit 0 is clear. Its count field is bits CNT_W-2:0 and its OF flag is bit 63.
- R3: While a slot's inhibit bit (register at 0x058, bit n for slot n) is set, that slot's counter holds its value.
- R4: Selector bits 14:0 hold an event ID. ID k in 1..8 counts each enabled cycle in which `ev_hit[k-1]` is high. ID 0, and any ID above 8, never counts.
- R5: When selector bit 60 is set, an event counts only if `ev_pid` equals selector bits 35:16.
- R6: When selector bit 61 is set, an event counts only if `ev_did` equals selector bits 59:36. When bit 60 or bit 61 is set, `ev_idt` must also equal selector bit 62.
- R7: When selector bit 15 is set, tag comparisons ignore every bit below the lowest clear bit of the programmed value.
- R8: A wrap of slot n sets bit n of the overflow status register (0x050). If the slot's OF flag was clear, OF becomes set and `irq` rises. If OF was already set, only the status bit is set. For event slots, OF is selector bit 63.
- R9: Status bits are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. `irq` drops once no interrupting overflow is left uncleared.
- R10: Counter n sits at 0x060+8n and the selector for slot n≥1 at 0x160+8(n-1). Slot 0 has no selector. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` |
| ev_hit | input | 8 | Per-event pulse, bit k-1 for event ID k |
| ev_pid | input | 20 | Process tag of this cycle's events |
| ev_did | input | 24 | Device tag of this cycle's events |
| ev_idt | input | 1 | Tag type of this cycle's events |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the bank with four slots and 8-bit counters. With that width the cycle counter wraps after 128 edges and an event counter after 256, so wrap, OF suppression and status clearing are reachable within a few cycles of presetting a counter near all ones. Four slots keep one cycle counter, one slot sweeping every event ID, one slot cycling through filter cases and one slot for an event wrap, all in separate address windows.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int EV_TYPES = 8;
  localparam int PID_W    = 20;
  localparam int DID_W    = 24;
  localparam int ADDR_W   = 12;

  localparam logic [ADDR_W-1:0] OVF_ADDR = 12'h050;
  localparam logic [ADDR_W-1:0] INH_ADDR = 12'h058;
  localparam logic [ADDR_W-1:0] CTR_BASE = 12'h060;
  localparam logic [ADDR_W-1:0] SEL_BASE = 12'h160;

  // Tag compare; partial mode masks bits below the lowest zero of prog.
  function automatic logic tag_eq(input logic [DID_W-1:0] prog,
                                  input logic [DID_W-1:0] tag,
                                  input logic partial);
    logic [DID_W:0]   span;
    logic [DID_W-1:0] ign;
    span = {1'b0, prog} ^ ({1'b0, prog} + 1'b1);
    ign  = partial ? span[DID_W:1] : '0;
    return ((prog ^ tag) & ~ign) == '0;
  endfunction
endpackage

// File: rtl/hpm_slot.sv
module hpm_slot
  import hpm_pkg::*;
#(
  parameter bit IS_CYCLE = 1'b0,
  parameter int CNT_W    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_we,
  input  logic                sel_we,
  input  logic                run,
  input  logic [63:0]         wdata,
  input  logic [EV_TYPES-1:0] ev_hit,
  input  logic [PID_W-1:0]    ev_pid,
  input  logic [DID_W-1:0]    ev_did,
  input  logic                ev_idt,
  output logic [63:0]         cnt_rd,
  output logic [63:0]         sel_rd,
  output logic                wrap,
  output logic                fire
);
  localparam int CW = IS_CYCLE ? CNT_W - 1 : CNT_W;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          of_q, of_d, of_we;
  logic          hit, inc;

  generate
    if (IS_CYCLE) begin : g_cyc
      logic unused_cyc;
      assign unused_cyc = ^{sel_we, ev_hit, ev_pid, ev_did, ev_idt};
      assign hit    = 1'b1;
      assign of_we  = cnt_we;
      assign sel_rd = '0;
    end else begin : g_evt
      logic [62:0] sel_q, sel_d;
      logic        id_hit, pid_ok, did_ok, idt_ok;

      always_comb begin
        id_hit = 1'b0;
        for (int k = 0; k < EV_TYPES; k++)
          if (sel_q[14:0] == 15'(k + 1)) id_hit = ev_hit[k];
        pid_ok = !sel_q[60] ||
                 tag_eq({{(DID_W-PID_W){1'b0}}, sel_q[35:16]},
                        {{(DID_W-PID_W){1'b0}}, ev_pid}, sel_q[15]);
        did_ok = !sel_q[61] || tag_eq(sel_q[59:36], ev_did, sel_q[15]);
        idt_ok = !(sel_q[60] || sel_q[61]) || (ev_idt == sel_q[62]);
        sel_d  = sel_we ? wdata[62:0] : sel_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else if (sel_we) sel_q <= sel_d;
      end

      assign hit    = id_hit && pid_ok && did_ok && idt_ok;
      assign of_we  = sel_we;
      assign sel_rd = {of_q, sel_q};
    end
  endgenerate

  assign inc  = run && hit;
  assign wrap = inc && !cnt_we && (&cnt_q);
  assign fire = wrap && !of_q;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)   cnt_d = wdata[CW-1:0];
    else if (inc) cnt_d = cnt_q + 1'b1;
    of_d = of_q;
    if (of_we)     of_d = wdata[63];
    else if (fire) of_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      of_q  <= 1'b0;
    end else begin
      if (cnt_we || inc)  cnt_q <= cnt_d;
      if (of_we || fire)  of_q  <= of_d;
    end
  end

  always_comb begin
    cnt_rd = '0;
    cnt_rd[CW-1:0] = cnt_q;
    if (IS_CYCLE) cnt_rd[63] = of_q;
  end
endmodule

// File: rtl/hpm_bank.sv
module hpm_bank
  import hpm_pkg::*;
#(
  parameter int NUM_CTR = 32,
  parameter int CNT_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [63:0]         bus_wdata,
  output logic [63:0]         bus_rdata,
  input  logic [EV_TYPES-1:0] ev_hit,
  input  logic [PID_W-1:0]    ev_pid,
  input  logic [DID_W-1:0]    ev_did,
  input  logic                ev_idt,
  output logic                irq
);
  logic [NUM_CTR-1:0] inh_q, inh_d, ovf_q, ovf_d, pend_q, pend_d;
  logic [NUM_CTR-1:0] wrap_v, fire_v, cnt_we, sel_we, clr_v;
  logic               inh_we, ovf_we;
  logic [63:0]        cnt_rd [NUM_CTR];
  logic [63:0]        sel_rd [NUM_CTR];

  assign inh_we = bus_wr && (bus_addr == INH_ADDR);
  assign ovf_we = bus_wr && (bus_addr == OVF_ADDR);

  generate
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_slot
      assign cnt_we[n] = bus_wr && (bus_addr == ADDR_W'(CTR_BASE + 8 * n));
      if (n == 0) begin : g_nosel
        assign sel_we[n] = 1'b0;
      end else begin : g_sel
        assign sel_we[n] = bus_wr && (bus_addr == ADDR_W'(SEL_BASE + 8 * (n - 1)));
      end
      hpm_slot #(.IS_CYCLE(n == 0), .CNT_W(CNT_W)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_we (cnt_we[n]),
        .sel_we (sel_we[n]),
        .run    (!inh_q[n]),
        .wdata  (bus_wdata),
        .ev_hit (ev_hit),
        .ev_pid (ev_pid),
        .ev_did (ev_did),
        .ev_idt (ev_idt),
        .cnt_rd (cnt_rd[n]),
        .sel_rd (sel_rd[n]),
        .wrap   (wrap_v[n]),
        .fire   (fire_v[n])
      );
    end
  endgenerate

  always_comb begin
    clr_v  = ovf_we ? bus_wdata[NUM_CTR-1:0] : '0;
    inh_d  = inh_we ? bus_wdata[NUM_CTR-1:0] : inh_q;
    ovf_d  = (ovf_q & ~clr_v) | wrap_v;
    pend_d = (pend_q & ~clr_v) | fire_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q  <= '1;
      ovf_q  <= '0;
      pend_q <= '0;
    end else begin
      if (inh_we) inh_q <= inh_d;
      if (ovf_we || (|wrap_v)) begin
        ovf_q  <= ovf_d;
        pend_q <= pend_d;
      end
    end
  end

  assign irq = |pend_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OVF_ADDR) bus_rdata[NUM_CTR-1:0] = ovf_q;
    if (bus_addr == INH_ADDR) bus_rdata[NUM_CTR-1:0] = inh_q;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (bus_addr == ADDR_W'(CTR_BASE + 8 * n)) bus_rdata = cnt_rd[n];
      if (n > 0 && bus_addr == ADDR_W'(SEL_BASE + 8 * n - 8)) bus_rdata = sel_rd[n];
    end
  end
endmodule

// File: rtl/hpm_bank_chk.sv
module hpm_bank_chk #(
  parameter int NUM_CTR = 32,
  parameter int CNT_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [NUM_CTR-1:0] inh_q,
  input logic [NUM_CTR-1:0] ovf_q,
  input logic [NUM_CTR-1:0] pend_q,
  input logic               irq,
  input logic [63:0]        cyc_rd
);
  localparam int CW = CNT_W - 1;
  logic [CW-1:0] cyc_cnt, cyc_inc;
  assign cyc_cnt = cyc_rd[CW-1:0];
  assign cyc_inc = cyc_cnt + 1'b1;

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !inh_q[0]) |=> (cyc_cnt == $past(cyc_inc))); // R2
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && inh_q[0]) |=> $stable(cyc_rd)); // R3
  AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~ovf_q) == '0)); // R8
  AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_q != '0)); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R9
endmodule

bind hpm_bank hpm_bank_chk #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .bus_wr (bus_wr),
  .inh_q  (inh_q),
  .ovf_q  (ovf_q),
  .pend_q (pend_q),
  .irq    (irq),
  .cyc_rd (cnt_rd[0])
);

// File: tb/hpm_bank_bench.sv
`timescale 1ns/1ps
module hpm_bank_bench;
  localparam int N  = 4;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [7:0]  ev_hit = '0;
  logic [19:0] ev_pid = '0;
  logic [23:0] ev_did = '0;
  logic        ev_idt = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  hpm_bank #(.NUM_CTR(N), .CNT_W(CW)) u_hpm_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_hit(ev_hit),
    .ev_pid(ev_pid), .ev_did(ev_did), .ev_idt(ev_idt), .irq(irq)
  );

  localparam logic [11:0] A_OVF = 12'h050;
  localparam logic [11:0] A_INH = 12'h058;
  function automatic logic [11:0] a_ctr(input int n); return 12'(12'h060 + 8 * n); endfunction
  function automatic logic [11:0] a_sel(input int n); return 12'(12'h160 + 8 * (n - 1)); endfunction

  function automatic logic [63:0] mk_sel(input int id, input bit pm, input logic [19:0] pid,
                                         input logic [23:0] did, input bit pv, input bit dv,
                                         input bit idt);
    return {1'b0, idt, dv, pv, did, pid, pm, 15'(id)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Clears the inhibit bits in mask for exactly n counting edges.
  task automatic run(input logic [N-1:0] mask, input int n);
    wr(A_INH, 64'(~mask));
    repeat (n - 1) @(posedge clk);
    wr(A_INH, 64'({N{1'b1}}));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] c1_hold;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_INH, v); chk("R1 inhibit", v, 64'hF);
    rd(A_OVF, v); chk("R1 status", v, 0);
    for (int n = 0; n < N; n++) begin rd(a_ctr(n), v); chk("R1 counter", v, 0); end
    for (int n = 1; n < N; n++) begin rd(a_sel(n), v); chk("R1 selector", v, 0); end
    chk("R1 irq", 64'(irq), 0);

    // R10 unmapped / no selector for slot 0
    rd(12'h000, v); chk("R10 unmapped", v, 0);
    rd(12'h158, v); chk("R10 no cycle selector", v, 0);

    // R2 cycle counter runs
    run(4'b0001, 10);
    rd(a_ctr(0), v); chk("R2 cycle count", v, 64'd10);
    // R3 frozen when inhibited
    repeat (5) @(posedge clk);
    rd(a_ctr(0), v); chk("R3 cycle frozen", v, 64'd10);

    // R8 cycle wrap with OF clear
    wr(a_ctr(0), 64'h7D);
    run(4'b0001, 3);
    rd(a_ctr(0), v); chk("R8 cycle wrap sets OF", v, 64'h8000_0000_0000_0000);
    rd(A_OVF, v);    chk("R8 status bit0", v, 64'h1);
    chk("R8 irq raised", 64'(irq), 1);
    // R9 write 0 leaves, write 1 clears
    wr(A_OVF, 64'h0);
    rd(A_OVF, v); chk("R9 zero write keeps", v, 64'h1);
    wr(A_OVF, 64'h1);
    rd(A_OVF, v); chk("R9 W1C clears", v, 0);
    chk("R9 irq dropped", 64'(irq), 0);
    // R8 wrap with OF already set: status only
    wr(a_ctr(0), 64'h8000_0000_0000_007F);
    run(4'b0001, 1);
    rd(a_ctr(0), v); chk("R8 suppressed wrap count", v, 64'h8000_0000_0000_0000);
    rd(A_OVF, v);    chk("R8 suppressed status", v, 64'h1);
    chk("R8 suppressed irq", 64'(irq), 0);
    wr(A_OVF, 64'h1);

    // R4 event ID sweep on slot 1
    ev_hit = 8'b1010_0101;
    for (int id = 0; id < 10; id++) begin
      int exp;
      exp = (id >= 1 && id <= 8 && ev_hit[id-1]) ? 5 : 0;
      wr(a_sel(1), mk_sel(id, 0, 0, 0, 0, 0, 0));
      wr(a_ctr(1), 0);
      run(4'b0010, 5);
      rd(a_ctr(1), v); chk($sformatf("R4 event id %0d", id), v, 64'(exp));
    end
    rd(a_sel(1), v); chk("R10 selector readback", v, 64'd9);

    // slot 1 stays inhibited through filter tests (R3)
    wr(a_sel(1), mk_sel(1, 0, 0, 0, 0, 0, 0));
    wr(a_ctr(1), 64'h33);
    c1_hold = 64'h33;
    ev_hit = 8'b0000_0011;

    // R5 process filter
    wr(a_sel(2), mk_sel(2, 0, 20'h12345, 0, 1, 0, 0));
    ev_pid = 20'h12345;
    wr(a_ctr(2), 0); run(4'b0100, 4);
    rd(a_ctr(2), v); chk("R5 pid match", v, 4);
    ev_pid = 20'h12344;
    wr(a_ctr(2), 0); run(4'b0100, 4);
    rd(a_ctr(2), v); chk("R5 pid mismatch", v, 0);

    // R7 partial matching: prog 0x7 ignores bits 2:0
    wr(a_sel(2), mk_sel(2, 1, 20'h00007, 0, 1, 0, 0));
    ev_pid = 20'h00005;
    wr(a_ctr(2), 0); run(4'b0100, 4);
    rd(a_ctr(2), v); chk("R7 partial match", v, 4);
    ev_pid = 20'h0000D;
    wr(a_ctr(2), 0); run(4'b0100, 4);
    rd(a_ctr(2), v); chk("R7 partial bit3 differs", v, 0);
    wr(a_sel(2), mk_sel(2, 0, 20'h00007, 0, 1, 0, 0));
    ev_pid = 20'h00005;
    wr(a_ctr(2), 0); run(4'b0100, 4);
    rd(a_ctr(2), v); chk("R7 exact when partial off", v, 0);

    // R6 device filter and tag type
    wr(a_sel(2), mk_sel(2, 0, 0, 24'hABCDE, 0, 1, 0));
    ev_did = 24'hABCDE; ev_idt = 1'b0;
    wr(a_ctr(2), 0); run(4'b0100, 4);
    rd(a_ctr(2), v); chk("R6 did match", v, 4);
    ev_did = 24'hABCDF;
    wr(a_ctr(2), 0); run(4'b0100, 4);
    rd(a_ctr(2), v); chk("R6 did mismatch", v, 0);
    wr(a_sel(2), mk_sel(2, 0, 0, 24'hABCDE, 0, 1, 1));
    ev_did = 24'hABCDE; ev_idt = 1'b0;
    wr(a_ctr(2), 0); run(4'b0100, 4);
    rd(a_ctr(2), v); chk("R6 type mismatch", v, 0);

    rd(a_ctr(1), v); chk("R3 inhibited event slot holds", v, c1_hold);

    // R8 event wrap on slot 3, OF in selector bit 63
    ev_hit = 8'h08;
    wr(a_sel(3), mk_sel(4, 0, 0, 0, 0, 0, 0));
    wr(a_ctr(3), 64'hFE);
    run(4'b1000, 2);
    rd(a_ctr(3), v); chk("R8 event wrap count", v, 0);
    rd(A_OVF, v);    chk("R8 event status", v, 64'h8);
    rd(a_sel(3), v); chk("R8 event OF set", v, 64'h8000_0000_0000_0004);
    chk("R8 event irq", 64'(irq), 1);
    wr(A_OVF, 64'h8);
    chk("R9 event irq cleared", 64'(irq), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule